// File: doc/BRIEF.md
# Two's Complement Add / Subtract / Negate Unit

This combinational unit works on two N-bit two's complement operands (8 bits unless the parameter is changed). A single ripple adder serves every operation: subtraction feeds it the complemented second operand with a carry-in of one, and negation feeds it the complemented first operand against a zero addend, again with a carry-in of one. A fourth operation passes the first operand through unchanged.

Alongside the N-bit result the unit reports the adder's raw top-bit carry, a signed overflow flag, a zero flag, and a 2N-bit copy of the result whose upper half repeats the sign bit. Values span -2^(N-1) to 2^(N-1)-1, and zero has one encoding. The unit holds no state and has no clock. Its outputs follow its inputs within one combinational delay.

Top module: `tc_addsub`

## Requirements
- R1: With `op_sel` = 2'b00 (add), `result` equals (A + B) mod 2^N and `carry_out` is the carry out of the unsigned N-bit sum.
- R2: With `op_sel` = 2'b01 (subtract), `result` equals (A - B) mod 2^N, formed as A + ~B + 1, and `carry_out` is 1 exactly when A >= B as unsigned numbers.
- R3: For add, `overflow` is 1 exactly when A and B share a sign and the result's sign differs. For subtract, it is 1 exactly when A and B differ in sign and the result's sign differs from A's. In both cases this equals the true signed result falling outside -2^(N-1)..2^(N-1)-1.
- R4: With `op_sel` = 2'b10 (negate), `result` equals (~A + 1) mod 2^N, B is ignored, and `carry_out` is 1 only when A is zero.
- R5: Negate raises `overflow` only for the most negative value (sign bit 1, all other bits 0). That value comes back unchanged. Negating zero yields zero with `overflow` at 0.
- R6: With `op_sel` = 2'b11 (pass), `result` equals A, B is ignored, and `carry_out` and `overflow` are both 0.
- R7: `result_wide` holds `result` in its low N bits, and every upper bit equals bit N-1 of `result`.
- R8: `zero` is 1 exactly when all N bits of `result` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand; the one negated or passed |
| op_b | input | WIDTH | Second operand (addend or subtrahend) |
| op_sel | input | 2 | Operation: 00 add, 01 subtract, 10 negate, 11 pass |
| result | output | WIDTH | N-bit result |
| result_wide | output | 2*WIDTH | Sign-extended copy of the result |
| carry_out | output | 1 | Raw carry out of the adder's top bit |
| overflow | output | 1 | Signed overflow for the selected operation |
| zero | output | 1 | Result is all zeros |

## Verification
The unit holds no state, so any fault shows at the ports during the same input pattern that exposes it. No later cycle is needed. The bench drives inputs and samples half a clock period later. A wrong operand selection or carry-in shows up as a result off by one or complemented. A wrong overflow term shows up as a flag that disagrees with the true signed range. The directed cases cover the sign-boundary operands, zero and the most negative value, and a stepped grid covers many patterns in all four modes.

// File: rtl/tc_addsub.sv
module tc_addsub #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]   op_a,
  input  logic [WIDTH-1:0]   op_b,
  input  logic [1:0]         op_sel,
  output logic [WIDTH-1:0]   result,
  output logic [2*WIDTH-1:0] result_wide,
  output logic               carry_out,
  output logic               overflow,
  output logic               zero
);
  localparam int WIDE = 2 * WIDTH;
  localparam int MSB  = WIDTH - 1;
  localparam int EXT  = WIDE - WIDTH;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_NEG  = 2'b10,
    OP_PASS = 2'b11
  } op_e;

  logic [WIDTH-1:0] lhs;
  logic [WIDTH-1:0] rhs;
  logic             cin;
  logic [WIDTH:0]   total;

  always_comb begin
    lhs = op_a;
    rhs = '0;
    cin = 1'b0;
    case (op_e'(op_sel))
      OP_ADD:  begin lhs = op_a; rhs = op_b;  cin = 1'b0; end
      OP_SUB:  begin lhs = op_a; rhs = ~op_b; cin = 1'b1; end
      OP_NEG:  begin lhs = '0;   rhs = ~op_a; cin = 1'b1; end
      default: begin lhs = op_a; rhs = '0;    cin = 1'b0; end
    endcase
  end

  assign total     = {1'b0, lhs} + {1'b0, rhs} + {{WIDTH{1'b0}}, cin};
  assign result    = total[MSB:0];
  assign carry_out = total[WIDTH];

  always_comb begin
    case (op_e'(op_sel))
      OP_ADD, OP_SUB: overflow = (lhs[MSB] == rhs[MSB]) && (result[MSB] != lhs[MSB]);
      OP_NEG:         overflow = (op_a != '0) && (result[MSB] == op_a[MSB]);
      default:        overflow = 1'b0;
    endcase
  end

  assign result_wide = {{EXT{result[MSB]}}, result};
  assign zero        = ~|result;
endmodule

// File: rtl/tc_addsub_chk.sv
module tc_addsub_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0]   op_a,
  input logic [WIDTH-1:0]   op_b,
  input logic [1:0]         op_sel,
  input logic [WIDTH-1:0]   result,
  input logic [2*WIDTH-1:0] result_wide,
  input logic               carry_out,
  input logic               overflow,
  input logic               zero
);
  localparam int MSB = WIDTH - 1;
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] sum_chk;
  logic [WIDTH-1:0] neg_chk;

  always_comb begin
    sum_chk = result + op_b;
    neg_chk = result + op_a;
    if (op_sel == 2'b01)
      assert_sub_R2: assert (sum_chk == op_a);
    if (op_sel == 2'b00 && overflow)
      assert_add_ovf_R3: assert (op_a[MSB] == op_b[MSB] && result[MSB] != op_a[MSB]);
    if (op_sel == 2'b10)
      assert_neg_R4: assert (neg_chk == '0);
    if (op_sel == 2'b10)
      assert_neg_ovf_R5: assert (overflow == (op_a == MOST_NEG));
    if (op_sel == 2'b11)
      assert_pass_R6: assert (result == op_a && !carry_out && !overflow);
    assert_ext_R7: assert ($signed(result_wide) == $signed(result));
    assert_zero_R8: assert (zero == (result == '0));
  end
endmodule

bind tc_addsub tc_addsub_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_tc_addsub.sv
module sim_tc_addsub;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0]   op_a = '0;
  logic [W-1:0]   op_b = '0;
  logic [1:0]     op_sel = 2'b00;
  logic [W-1:0]   result;
  logic [2*W-1:0] result_wide;
  logic           carry_out;
  logic           overflow;
  logic           zero;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  tc_addsub #(.WIDTH(W)) u0 (
    .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .result(result), .result_wide(result_wide),
    .carry_out(carry_out), .overflow(overflow), .zero(zero)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (a=%0d b=%0d op=%0d)",
               tag, what, act, exp, op_a, op_b, op_sel);
    end
  endtask

  task automatic run_vec(input int a, input int b, input int op);
    int sa, sb, s, u, er, ec, eo, ew;
    string tr, tf;
    @(posedge clk);
    op_a = W'(a); op_b = W'(b); op_sel = 2'(op);
    @(negedge clk);
    sa = (a >= 128) ? a - 256 : a;
    sb = (b >= 128) ? b - 256 : b;
    case (op)
      0: begin u = a + b; s = sa + sb; ec = (u > 255) ? 1 : 0; tr = "R1"; tf = "R3"; end
      1: begin s = sa - sb; ec = (a >= b) ? 1 : 0; tr = "R2"; tf = "R3"; end
      2: begin s = -sa; ec = (a == 0) ? 1 : 0; tr = "R4"; tf = "R5"; end
      default: begin s = sa; ec = 0; tr = "R6"; tf = "R6"; end
    endcase
    er = s & 255;
    eo = (s > 127 || s < -128) ? 1 : 0;
    ew = s & 65535;
    if (s < -128 || s > 127) ew = (er >= 128) ? er + 65280 : er;
    check(tr, "result", int'(result), er);
    check(tr, "carry", int'(carry_out), ec);
    check(tf, "overflow", int'(overflow), eo);
    check("R7", "wide", int'(result_wide), ew);
    check("R8", "zero", int'(zero), (er == 0) ? 1 : 0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    check("R8", "idle zero", int'(zero), 1);
    check("R1", "idle result", int'(result), 0);
  endtask

  task automatic t_add;
    run_vec(3, 4, 0);
    run_vec(127, 1, 0);
    run_vec(128, 255, 0);
    run_vec(255, 1, 0);
    run_vec(200, 100, 0);
    run_vec(64, 64, 0);
  endtask

  task automatic t_sub;
    run_vec(5, 3, 1);
    run_vec(3, 5, 1);
    run_vec(128, 1, 1);
    run_vec(127, 255, 1);
    run_vec(0, 128, 1);
    run_vec(9, 9, 1);
  endtask

  task automatic t_neg;
    run_vec(0, 77, 2);
    run_vec(128, 5, 2);
    run_vec(1, 0, 2);
    run_vec(127, 200, 2);
    run_vec(255, 3, 2);
  endtask

  task automatic t_pass;
    run_vec(128, 255, 3);
    run_vec(0, 1, 3);
    run_vec(200, 17, 3);
  endtask

  task automatic t_grid;
    for (int a = 0; a < 256; a += 17)
      for (int b = 0; b < 256; b += 23)
        for (int op = 0; op < 4; op++)
          run_vec(a, b, op);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    t_idle();
    t_add();
    t_sub();
    t_neg();
    t_pass();
    t_grid();
    finish_run();
  end

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule